// File: doc/BRIEF.md
# Receive Flow Control and Timeout Monitor

This block sits beside a UART receiver and its receive FIFO. It watches how full the FIFO is and which receiver events occur, and from these it drives the RTS line toward the remote sender and three status flags. RTS has hysteresis set by two programmable watermarks. Software can also override RTS and drive it directly. An idle timer counts bit periods after each received byte. It raises a timeout flag when received data has been left unread for long enough.

The block holds three configuration words: the high watermark, the low watermark and the idle delay. Each is loaded by its own write strobe from a shared data bus. Three small state machines do the work:

- **RTS hysteresis machine.** States `RTS_RELEASED` and `RTS_ASSERTED`. Transition *raise* goes RELEASED→ASSERTED when count > high mark. Transition *drop* goes ASSERTED→RELEASED when count < low mark and count is not above the high mark.
- **Idle timer.** States `IDLE_DISARMED` and `IDLE_COUNTING`. Transition *arm* goes DISARMED→COUNTING on a stored byte. Transition *rearm* goes COUNTING→COUNTING on a stored byte and zeroes the counter. Transition *cancel* goes COUNTING→DISARMED on a start bit.
- **Overrun machine.** States `OVR_CLEAR` and `OVR_LATCHED`. Transition *catch* goes CLEAR→LATCHED when a byte arrives while the FIFO is full. Transition *acknowledge* goes LATCHED→CLEAR on a clear pulse.

Top module: `rx_flow_monitor`

## Requirements
- R1: After reset, the high watermark is all ones, the low watermark is 0 and the idle delay is 0. Both RTS-machine and idle-timer states are released or disarmed, and `rts` (with `force_rts`=0), `rx_high`, `rx_timeout` and `rx_overrun` are all 0.
- R2: With `force_rts`=0, `rts` becomes 1 in the cycle after a clock edge at which `fifo_count` > high watermark.
- R3: With `force_rts`=0, `rts` becomes 0 in the cycle after a clock edge at which `fifo_count` < low watermark. While the count lies within both marks, `rts` keeps its value. If the count is above the high mark and below the low mark at once, the high mark wins and `rts` goes or stays 1.
- R4: With `force_rts`=1, `rts` equals `rts_value` in the same cycle. The hysteresis state keeps tracking the count underneath.
- R5: `rx_high` is 1 exactly while `fifo_count` > the current high watermark, with no cycle of delay.
- R6: A write strobe (`hi_wr`, `lo_wr`, `dly_wr`) loads `cfg_data` into its register at the clock edge. The new value governs the outputs from the following cycle onward.
- R7: A `byte_stored` pulse arms the idle counter and sets it to 0. Each `bit_tick` while armed adds 1, and the counter stops at 2^DLY_W−1. A `start_seen` pulse disarms and clears it, and wins over a simultaneous `byte_stored`.
- R8: `rx_timeout` = armed AND `fifo_count`≠0 AND idle count ≥ delay. It is not sticky. With a delay of 0 it is 1 in the cycle after the arming byte if the FIFO is non-empty.
- R9: `rx_overrun` becomes 1 in the cycle after a `byte_stored` pulse seen with `fifo_full`=1. It stays 1 until a `status_clr` pulse, and a new overrun in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_count | input | CNT_W | Current receive FIFO occupancy |
| fifo_full | input | 1 | Receive FIFO full |
| byte_stored | input | 1 | Pulse: a byte completed with its stop bit |
| start_seen | input | 1 | Pulse: receiver detected a start bit |
| bit_tick | input | 1 | Pulse: one bit period elapsed |
| status_clr | input | 1 | Pulse: clears the sticky overrun flag |
| hi_wr | input | 1 | Load high watermark |
| lo_wr | input | 1 | Load low watermark |
| dly_wr | input | 1 | Load idle delay |
| cfg_data | input | CFG_W | Shared configuration write data |
| force_rts | input | 1 | 1: RTS follows `rts_value` |
| rts_value | input | 1 | Software RTS level |
| rts | output | 1 | Flow-control output to the sender |
| rx_high | output | 1 | Count above high watermark |
| rx_timeout | output | 1 | Unread data idle past the delay |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong hysteresis state shows on `rts` one cycle after the count crosses a mark. With the count parked between the marks, the fault stays visible for as long as the count stays there. A wrong idle count or armed state shows on `rx_timeout` in the first cycle where the count is compared against the delay: a delay of 0, a delay reached after a few ticks, and the saturation limit. A lost or stuck overrun state shows on `rx_overrun` in the cycle after the offending byte or the clear pulse. Because the reference model is compared on every clock, each such error is reported in the cycle it first reaches a port.

// File: rtl/rxfm_pkg.sv
package rxfm_pkg;

    typedef enum logic {
        RTS_RELEASED = 1'b0,
        RTS_ASSERTED = 1'b1
    } rts_state_t;

    typedef enum logic {
        IDLE_DISARMED = 1'b0,
        IDLE_COUNTING = 1'b1
    } idle_state_t;

    typedef enum logic {
        OVR_CLEAR   = 1'b0,
        OVR_LATCHED = 1'b1
    } ovr_state_t;

endpackage

// File: rtl/rxfm_cfg_regs.sv
module rxfm_cfg_regs #(
    parameter int CNT_W = 8,
    parameter int DLY_W = 8,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic             dly_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic [CNT_W-1:0] high_mark,
    output logic [CNT_W-1:0] low_mark,
    output logic [DLY_W-1:0] delay
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_mark <= {CNT_W{1'b1}};
            low_mark  <= '0;
            delay     <= '0;
        end else begin
            if (hi_wr)  high_mark <= cfg_data[CNT_W-1:0];
            if (lo_wr)  low_mark  <= cfg_data[CNT_W-1:0];
            if (dly_wr) delay     <= cfg_data[DLY_W-1:0];
        end
    end

    // R6: a write is visible in the register on the next cycle
    p_hi_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> (high_mark == $past(cfg_data[CNT_W-1:0])));
    p_dly_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dly_wr |=> (delay == $past(cfg_data[DLY_W-1:0])));

endmodule

// File: rtl/rxfm_rts_ctrl.sv
module rxfm_rts_ctrl
    import rxfm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] high_mark,
    input  logic [CNT_W-1:0] low_mark,
    input  logic             force_rts,
    input  logic             rts_value,
    output logic             rts,
    output logic             rx_high
);

    rts_state_t state_q, state_d;
    logic       above_hi, below_lo;

    assign above_hi = (fifo_count > high_mark);
    assign below_lo = (fifo_count < low_mark);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_RELEASED: if (above_hi)              state_d = RTS_ASSERTED; // raise
            RTS_ASSERTED: if (!above_hi && below_lo) state_d = RTS_RELEASED; // drop
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RTS_RELEASED;
        else        state_q <= state_d;
    end

    always_comb begin
        rx_high = above_hi;
        rts     = force_rts ? rts_value : (state_q == RTS_ASSERTED);
    end

    // R2: crossing the high mark asserts the hysteresis state next cycle
    p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count > high_mark) |=> (state_q == RTS_ASSERTED));
    // R3: between the marks the state does not move
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_count <= high_mark) && (fifo_count >= low_mark)) |=> $stable(state_q));
    // R3: below the low mark alone releases next cycle
    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fifo_count < low_mark) && (fifo_count <= high_mark)) |=> (state_q == RTS_RELEASED));

endmodule

// File: rtl/rxfm_idle_timer.sv
module rxfm_idle_timer
    import rxfm_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_stored,
    input  logic             start_seen,
    input  logic             bit_tick,
    input  logic             fifo_nonempty,
    input  logic [DLY_W-1:0] delay,
    output logic             rx_timeout
);

    localparam logic [DLY_W-1:0] IDLE_MAX = {DLY_W{1'b1}};

    idle_state_t      state_q, state_d;
    logic [DLY_W-1:0] idle_q, idle_d;

    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        unique case (state_q)
            IDLE_DISARMED: begin
                if (byte_stored && !start_seen) begin      // arm
                    state_d = IDLE_COUNTING;
                    idle_d  = '0;
                end
            end
            IDLE_COUNTING: begin
                if (start_seen) begin                      // cancel
                    state_d = IDLE_DISARMED;
                    idle_d  = '0;
                end else if (byte_stored) begin            // rearm
                    idle_d  = '0;
                end else if (bit_tick && idle_q != IDLE_MAX) begin
                    idle_d  = idle_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDLE_DISARMED;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end

    always_comb begin
        rx_timeout = (state_q == IDLE_COUNTING) && fifo_nonempty && (idle_q >= delay);
    end

    // R7: a start bit leaves the timer disarmed and cleared
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (state_q == IDLE_DISARMED && idle_q == '0));
    // R7: a stored byte without start restarts the count from zero
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stored && !start_seen) |=> (state_q == IDLE_COUNTING && idle_q == '0));
    // R7: the counter sticks at its maximum
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDLE_COUNTING && idle_q == IDLE_MAX && !start_seen && !byte_stored)
        |=> (idle_q == IDLE_MAX));
    // R8: an empty FIFO never reports a timeout
    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_nonempty) |-> !rx_timeout);

endmodule

// File: rtl/rxfm_overrun.sv
module rxfm_overrun
    import rxfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic byte_stored,
    input  logic fifo_full,
    input  logic status_clr,
    output logic rx_overrun
);

    ovr_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_CLEAR:   if (byte_stored && fifo_full)                    state_d = OVR_LATCHED; // catch
            OVR_LATCHED: if (status_clr && !(byte_stored && fifo_full))   state_d = OVR_CLEAR;   // acknowledge
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVR_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        rx_overrun = (state_q == OVR_LATCHED);
    end

    // R9: a byte into a full FIFO latches the flag
    p_catch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stored && fifo_full) |=> rx_overrun);
    // R9: without a clear the flag stays
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !status_clr) |=> rx_overrun);

endmodule

// File: rtl/rx_flow_monitor.sv
module rx_flow_monitor
    import rxfm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DLY_W = 8,
    parameter int CFG_W = (CNT_W > DLY_W) ? CNT_W : DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_full,
    input  logic             byte_stored,
    input  logic             start_seen,
    input  logic             bit_tick,
    input  logic             status_clr,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic             dly_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             force_rts,
    input  logic             rts_value,
    output logic             rts,
    output logic             rx_high,
    output logic             rx_timeout,
    output logic             rx_overrun
);

    logic [CNT_W-1:0] high_mark, low_mark;
    logic [DLY_W-1:0] delay;
    logic             fifo_nonempty;

    assign fifo_nonempty = (fifo_count != '0);

    rxfm_cfg_regs #(.CNT_W(CNT_W), .DLY_W(DLY_W), .CFG_W(CFG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_wr     (hi_wr),
        .lo_wr     (lo_wr),
        .dly_wr    (dly_wr),
        .cfg_data  (cfg_data),
        .high_mark (high_mark),
        .low_mark  (low_mark),
        .delay     (delay)
    );

    rxfm_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_count (fifo_count),
        .high_mark  (high_mark),
        .low_mark   (low_mark),
        .force_rts  (force_rts),
        .rts_value  (rts_value),
        .rts        (rts),
        .rx_high    (rx_high)
    );

    rxfm_idle_timer #(.DLY_W(DLY_W)) u_idle (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_stored   (byte_stored),
        .start_seen    (start_seen),
        .bit_tick      (bit_tick),
        .fifo_nonempty (fifo_nonempty),
        .delay         (delay),
        .rx_timeout    (rx_timeout)
    );

    rxfm_overrun u_ovr (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stored (byte_stored),
        .fifo_full   (fifo_full),
        .status_clr  (status_clr),
        .rx_overrun  (rx_overrun)
    );

    // R4: in forced mode the pin mirrors the software bit
    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_rts |-> (rts == rts_value));

endmodule

// File: tb/tb_rx_flow_monitor.sv
module tb_rx_flow_monitor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] fifo_count;
    logic       fifo_full, byte_stored, start_seen, bit_tick, status_clr;
    logic       hi_wr, lo_wr, dly_wr;
    logic [7:0] cfg_data;
    logic       force_rts, rts_value;
    logic       rts, rx_high, rx_timeout, rx_overrun;

    always #5 clk = ~clk;

    rx_flow_monitor dut (
        .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .fifo_full(fifo_full),
        .byte_stored(byte_stored), .start_seen(start_seen), .bit_tick(bit_tick),
        .status_clr(status_clr), .hi_wr(hi_wr), .lo_wr(lo_wr), .dly_wr(dly_wr),
        .cfg_data(cfg_data), .force_rts(force_rts), .rts_value(rts_value),
        .rts(rts), .rx_high(rx_high), .rx_timeout(rx_timeout), .rx_overrun(rx_overrun)
    );

    int    checks = 0;
    int    errors = 0;
    string scen   = "R1";

    // behavioural reference
    int m_hi, m_lo, m_dly, m_idle;
    bit m_rts_st, m_armed, m_ovr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 255; m_lo = 0; m_dly = 0; m_idle = 0;
            m_rts_st = 0; m_armed = 0; m_ovr = 0;
        end else begin
            if (int'(fifo_count) > m_hi)      m_rts_st = 1;
            else if (int'(fifo_count) < m_lo) m_rts_st = 0;
            if (start_seen) begin m_armed = 0; m_idle = 0; end
            else if (byte_stored) begin m_armed = 1; m_idle = 0; end
            else if (m_armed && bit_tick && m_idle < 255) m_idle++;
            if (byte_stored && fifo_full) m_ovr = 1;
            else if (status_clr)          m_ovr = 0;
            if (hi_wr)  m_hi  = int'(cfg_data);
            if (lo_wr)  m_lo  = int'(cfg_data);
            if (dly_wr) m_dly = int'(cfg_data);
        end
    end

    task automatic cmp(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s actual %0b expected %0b at %0t", tag, scen, name, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic e_rts, e_high, e_tmo;
        e_rts  = force_rts ? rts_value : m_rts_st;
        e_high = (int'(fifo_count) > m_hi);
        e_tmo  = m_armed && (fifo_count != 0) && (m_idle >= m_dly);
        cmp(force_rts ? "R4" : "R3", "rts", rts, e_rts);
        cmp("R5", "rx_high", rx_high, e_high);
        cmp("R8", "rx_timeout", rx_timeout, e_tmo);
        cmp("R9", "rx_overrun", rx_overrun, m_ovr);
    endtask

    // one clock: edge, settle, compare, then drop the single-cycle strobes
    task automatic step();
        @(posedge clk);
        #2;
        check_all();
        byte_stored = 0; start_seen = 0; bit_tick = 0; status_clr = 0;
        hi_wr = 0; lo_wr = 0; dly_wr = 0;
    endtask

    task automatic wr(input int sel, input int val);
        cfg_data = 8'(val);
        hi_wr = (sel == 0); lo_wr = (sel == 1); dly_wr = (sel == 2);
        step();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; fifo_count = 0; fifo_full = 0; byte_stored = 0; start_seen = 0;
        bit_tick = 0; status_clr = 0; hi_wr = 0; lo_wr = 0; dly_wr = 0;
        cfg_data = 0; force_rts = 0; rts_value = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1: reset values, all-ones high mark means 255 is not "above"
        scen = "R1";
        fifo_count = 8'd255;
        step();
        cmp("R1", "rts_after_reset", rts, 1'b0);
        cmp("R1", "high_after_reset", rx_high, 1'b0);
        fifo_count = 0;
        step();

        // R2/R3: hysteresis with marks 5 and 2
        scen = "R6";
        wr(0, 5); wr(1, 2);
        scen = "R2";
        for (int c = 0; c <= 8; c++) begin fifo_count = 8'(c); step(); end
        cmp("R2", "rts_high_after_rise", rts, 1'b1);
        scen = "R3";
        for (int c = 8; c >= 0; c--) begin fifo_count = 8'(c); step(); end
        cmp("R3", "rts_low_after_fall", rts, 1'b0);
        fifo_count = 3; repeat (3) step();
        cmp("R3", "rts_hold_between", rts, 1'b0);

        // R3: inverted marks, high mark wins
        wr(0, 3); wr(1, 6);
        fifo_count = 4; repeat (3) step();
        cmp("R3", "rts_conflict_high_wins", rts, 1'b1);
        fifo_count = 1; step(); step();

        // R4: forced mode, state keeps tracking underneath
        scen = "R4";
        force_rts = 1; rts_value = 1; #1; cmp("R4", "rts_forced_same_cycle", rts, 1'b1);
        step(); rts_value = 0; #1; cmp("R4", "rts_forced_low", rts, 1'b0);
        fifo_count = 9; step(); step();
        force_rts = 0; #1; cmp("R4", "tracked_state_under_force", rts, 1'b1);
        step();

        // R6: new high mark applies only from next cycle
        scen = "R6";
        fifo_count = 10; cfg_data = 20; hi_wr = 1; #1;
        cmp("R6", "old_mark_in_write_cycle", rx_high, 1'b1);
        step();
        cmp("R6", "new_mark_next_cycle", rx_high, 1'b0);
        wr(1, 0);

        // R7/R8: idle timer with delay 3
        scen = "R7";
        wr(2, 3);
        fifo_count = 1; byte_stored = 1; step();
        for (int k = 0; k < 4; k++) begin bit_tick = 1; step(); end
        cmp("R8", "timeout_after_delay", rx_timeout, 1'b1);
        fifo_count = 0; step();
        cmp("R8", "timeout_clears_when_empty", rx_timeout, 1'b0);
        fifo_count = 2; start_seen = 1; step();
        cmp("R7", "start_cancels", rx_timeout, 1'b0);
        byte_stored = 1; start_seen = 1; step();
        repeat (5) begin bit_tick = 1; step(); end
        cmp("R7", "start_wins_over_byte", rx_timeout, 1'b0);

        // R8: delay 0 fires right after arming
        wr(2, 0);
        byte_stored = 1; step();
        cmp("R8", "delay_zero_immediate", rx_timeout, 1'b1);

        // R7: saturation with delay 255
        wr(2, 255);
        byte_stored = 1; step();
        for (int k = 0; k < 254; k++) begin bit_tick = 1; step(); end
        cmp("R7", "not_yet_at_254", rx_timeout, 1'b0);
        for (int k = 0; k < 6; k++) begin bit_tick = 1; step(); end
        cmp("R7", "saturated_timeout", rx_timeout, 1'b1);

        // R9: overrun catch, sticky, clear, collision
        scen = "R9";
        fifo_full = 1; byte_stored = 1; step();
        cmp("R9", "overrun_set", rx_overrun, 1'b1);
        fifo_full = 0; repeat (3) step();
        cmp("R9", "overrun_sticky", rx_overrun, 1'b1);
        status_clr = 1; step();
        cmp("R9", "overrun_cleared", rx_overrun, 1'b0);
        fifo_full = 1; byte_stored = 1; status_clr = 1; step();
        cmp("R9", "set_wins_over_clear", rx_overrun, 1'b1);
        fifo_full = 0; status_clr = 1; step();

        // mixed random traffic against the model
        scen = "R5";
        for (int n = 0; n < 3000; n++) begin
            fifo_count  = 8'($urandom_range(0, 12));
            fifo_full   = ($urandom_range(0, 7) == 0);
            byte_stored = ($urandom_range(0, 9) == 0);
            start_seen  = ($urandom_range(0, 14) == 0);
            bit_tick    = ($urandom_range(0, 2) == 0);
            status_clr  = ($urandom_range(0, 19) == 0);
            force_rts   = ($urandom_range(0, 9) == 0);
            rts_value   = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 49) == 0) begin
                cfg_data = 8'($urandom_range(0, 12));
                case ($urandom_range(0, 2))
                    0: hi_wr = 1;
                    1: lo_wr = 1;
                    default: dly_wr = 1;
                endcase
            end
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule